// File: doc/BRIEF.md
# Two-Requester Hold-Until-Release Arbiter

This block shares one resource between two requesters. Each requester raises its request line and waits for its grant line. A grant, once issued, stays high for as long as the same request stays high. No other request can take the resource away while the grant is held. When the holder drops its request, the machine spends one cycle with both grants low before it makes a new choice.

A choice is made only from the idle state. If both requests are high at that moment, requester 0 wins. There are three legal states: idle, holding for requester 0, and holding for requester 1. The grants decode directly from the state, so at most one grant is ever high. Any unused state encoding falls back to idle.

The external reset is active low and clears the state asynchronously. Its release passes through a short synchronizer, so the machine leaves reset on a clock edge.

Top module: `arb2_hold_arbiter`

## Requirements
- R1: While `rst_n` is low, both grants are low. After `rst_n` rises, the machine stays in reset for `SYNC_STAGES` (default 2) rising clock edges. The first request can be granted on the edge after that.
- R2: In idle, with request 1 high and request 0 low, `gnt1_o` is high after the next rising edge.
- R3: In idle, with request 0 high, `gnt0_o` is high after the next rising edge, whatever request 1 is doing.
- R4: While `gnt0_o` is high and request 0 stays high, `gnt0_o` stays high on the next edge.
- R5: While `gnt1_o` is high and request 1 stays high, `gnt1_o` stays high on the next edge, even when request 0 is also high.
- R6: When the holder's request is low at an edge, both grants are low after that edge. This holds even if the other request is pending, so there is one idle cycle between any two grants.
- R7: `gnt0_o` and `gnt1_o` are never high at the same time.
- R8: In idle with both requests low, both grants stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req0_i | input | 1 | Request from requester 0 (the higher priority) |
| req1_i | input | 1 | Request from requester 1 |
| gnt0_o | output | 1 | Grant to requester 0 |
| gnt1_o | output | 1 | Grant to requester 1 |

## Verification
The bench targets the moments where the two requests collide:
- **Request 0 rises while requester 1 holds the grant.** A preemptive design would switch the grant straight to requester 0.
- **The holder releases while the other request is already waiting.** A design without the idle cycle would hand over on the same edge, leaving no cycle with both grants low.
- **Both requests rise together in idle.** Reversed priority would grant requester 1.
- **`rst_n` is asserted in the middle of a grant.** A synchronous-only reset, or a release counted wrongly, would keep the grant visible or issue it on the wrong edge.

// File: rtl/arb2_pkg.sv
package arb2_pkg;

  // Two-bit state code. The value 2'b11 is unused and falls back to idle.
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'b00,
    ARB_HOLD0 = 2'b01,
    ARB_HOLD1 = 2'b10
  } arb_state_e;

  typedef struct packed {
    logic g0;
    logic g1;
  } arb_grant_t;

endpackage

// File: rtl/arb2_rst_sync.sv
module arb2_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/arb2_next.sv
module arb2_next
  import arb2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync_n,
  input  arb_state_e state_q,
  input  logic       req0,
  input  logic       req1,
  output arb_state_e state_d,
  output arb_grant_t grant
);

  always_comb begin
    // Defaults first, so that no path leaves a value unassigned.
    state_d  = ARB_IDLE;
    grant.g0 = 1'b0;
    grant.g1 = 1'b0;
    case (state_q)
      ARB_IDLE: begin
        if (req0)      state_d = ARB_HOLD0;
        else if (req1) state_d = ARB_HOLD1;
        else           state_d = ARB_IDLE;
      end
      ARB_HOLD0: begin
        grant.g0 = 1'b1;
        if (req0) state_d = ARB_HOLD0;
      end
      ARB_HOLD1: begin
        grant.g1 = 1'b1;
        if (req1) state_d = ARB_HOLD1;
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  // R7: the grant decode never raises both lines together.
  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({grant.g0, grant.g1}));

endmodule

// File: rtl/arb2_state_reg.sv
module arb2_state_reg
  import arb2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync_n,
  input  arb_state_e state_d,
  output arb_state_e state_q
);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ARB_IDLE;
    else             state_q <= state_d;
  end

endmodule

// File: rtl/arb2_hold_arbiter.sv
module arb2_hold_arbiter
  import arb2_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req0_i,
  input  logic req1_i,
  output logic gnt0_o,
  output logic gnt1_o
);

  logic       rst_sync_n;
  arb_state_e state_q;
  arb_state_e state_d;
  arb_grant_t grant;

  arb2_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  arb2_next u_next (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .state_q    (state_q),
    .req0       (req0_i),
    .req1       (req1_i),
    .state_d    (state_d),
    .grant      (grant)
  );

  arb2_state_reg u_state (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .state_d    (state_d),
    .state_q    (state_q)
  );

  assign gnt0_o = grant.g0;
  assign gnt1_o = grant.g1;

  // R1: leaving reset, no grant is visible yet.
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (!gnt0_o && !gnt1_o));

  // R2: a lone request 1 seen in idle is granted on the next edge.
  assert_pick_one_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!gnt0_o && !gnt1_o && !req0_i && req1_i) |=> gnt1_o);

  // R3: request 0 seen in idle wins, whatever request 1 is doing.
  assert_pick_zero_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!gnt0_o && !gnt1_o && req0_i) |=> gnt0_o);

  // R4: grant 0 is held while its request stays high.
  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gnt0_o && req0_i) |=> gnt0_o);

  // R5: grant 1 is held while its request stays high; request 0 cannot preempt it.
  assert_hold_one_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gnt1_o && req1_i) |=> (gnt1_o && !gnt0_o));

  // R6: a release always leads to one cycle with both grants low.
  assert_release_gap_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((gnt0_o && !req0_i) || (gnt1_o && !req1_i)) |=> (!gnt0_o && !gnt1_o));

  // R8: idle with no request stays idle.
  assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!gnt0_o && !gnt1_o && !req0_i && !req1_i) |=> (!gnt0_o && !gnt1_o));

endmodule

// File: tb/test_arb2_hold_arbiter.sv
`timescale 1ns/1ps
module test_arb2_hold_arbiter;

  localparam int NVEC = 14;
  // Each entry is {req0, req1, expected gnt0, expected gnt1} for one clock.
  localparam logic [3:0] VEC [NVEC] = '{
    4'b00_00,  // R8: idle, nothing requested
    4'b01_01,  // R2: lone request 1 granted
    4'b01_01,  // R5: hold 1
    4'b11_01,  // R5: request 0 does not preempt
    4'b10_00,  // R6: release of 1, request 0 waits one idle cycle
    4'b10_10,  // R3: request 0 granted from idle
    4'b11_10,  // R4: hold 0 with request 1 pending
    4'b01_00,  // R6: release of 0, gap before request 1
    4'b01_01,  // R2: request 1 granted after the gap
    4'b00_00,  // R6: release of 1
    4'b11_10,  // R3: tie in idle goes to requester 0
    4'b10_10,  // R4: hold 0
    4'b00_00,  // R6: release of 0
    4'b00_00   // R8: idle stays quiet
  };
  localparam int VREQ [NVEC] = '{8, 2, 5, 5, 6, 3, 4, 6, 2, 6, 3, 4, 6, 8};

  logic clk = 1'b0;
  logic rst_n;
  logic req0, req1;
  logic gnt0, gnt1;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  arb2_hold_arbiter i_arb2_hold_arbiter (
    .clk    (clk),
    .rst_n  (rst_n),
    .req0_i (req0),
    .req1_i (req1),
    .gnt0_o (gnt0),
    .gnt1_o (gnt1)
  );

  task automatic check(input int rq, input logic [1:0] exp);
    checks++;
    if ({gnt0, gnt1} !== exp) begin
      errors++;
      $display("FAIL R%0d: grants actual %b expected %b at %0t", rq, {gnt0, gnt1}, exp, $time);
    end
    checks++;
    if (gnt0 && gnt1) begin
      errors++;
      $display("FAIL R7: grants actual %b expected one-hot or zero", {gnt0, gnt1});
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req0 = 1'b0; req1 = 1'b0;
    repeat (3) step();
    check(1, 2'b00);                    // R1: grants low in reset
    rst_n = 1'b1;
    repeat (2) step();                  // synchronizer release edges
    check(1, 2'b00);                    // R1: still idle right after release

    for (int i = 0; i < NVEC; i++) begin
      req0 = VEC[i][3];
      req1 = VEC[i][2];
      step();
      check(VREQ[i], VEC[i][1:0]);
    end

    // R1: reset asserted in the middle of a held grant.
    req0 = 1'b0; req1 = 1'b1;
    step();
    check(2, 2'b01);
    #3 rst_n = 1'b0;
    #1 check(1, 2'b00);                 // asynchronous clear, no edge needed
    step();
    rst_n = 1'b1;
    step();
    check(1, 2'b00);                    // first edge after release: still in reset
    step();
    check(1, 2'b00);                    // second edge releases the internal reset
    step();
    check(1, 2'b01);                    // R1: request granted on the following edge

    // R5: a long hold with request 0 toggling against it.
    for (int k = 0; k < 6; k++) begin
      req0 = k[0];
      step();
      check(5, 2'b01);
    end
    req1 = 1'b0; req0 = 1'b1;
    step();
    check(6, 2'b00);                    // R6: gap even with request 0 waiting
    step();
    check(3, 2'b10);
    req0 = 1'b0;
    step();
    check(6, 2'b00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule